// File: doc/BRIEF.md
# Digest-Tagged Classification Cache

This block keeps recent packet classification decisions without holding full header keys. Two folds of the key are computed. The narrow one picks a set. The wider one is a short digest that is stored as the tag, next to the classification result, in one of the ways of that set. A lookup compares the digest against every valid way of its set. It answers one cycle later with either a hit and the stored result, or a miss.

On a miss, the surrounding logic runs the full classifier and writes the outcome back through the insert port. An insert places the entry in the lowest-numbered empty way of the set. When the set is full, the least recently used way is evicted. Entries therefore age out one at a time, and the cache is never flushed as a whole.

The tag is a digest and not the key itself. Two keys that agree in both folds are indistinguishable, and such a false hit is accepted by design. A wider digest and fewer ways make false hits rarer.

Top module: `digest_cls_cache`

## Requirements
- R1: A lookup presented in cycle t yields exactly one of hit_o or miss_o in cycle t+1. Both outputs stay low in any cycle that follows a cycle without a lookup.
- R2: The set index is the XOR of all 4-bit slices of the 48-bit key. The digest is the XOR of its three 16-bit slices.
- R3: A lookup hits when a valid way of its set holds its digest, and res_o then shows that way's result. Distinct keys with equal set index and digest hit each other's entries.
- R4: A lookup that finds no valid way with its digest reports a miss, with res_o equal to zero.
- R5: An insert whose digest is absent from a set that has an empty way writes the lowest-numbered empty way.
- R6: An insert whose digest is absent from a full set replaces the least recently used way, and the other ways stay intact.
- R7: Each hit and each insert makes the touched way the most recently used one of its set.
- R8: An insert whose digest is already valid in the set overwrites that way's result and creates no second copy.
- R9: A lookup and an insert in the same cycle: the lookup sees the contents from before the insert. When both touch the same set, only the insert's recency update takes effect.
- R10: After reset, every way is empty, and in every set way 0 is the most recent and way 3 the least recent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_vld_i | input | 1 | Lookup request |
| lkp_key_i | input | 48 | Lookup classification key |
| ins_vld_i | input | 1 | Insert request |
| ins_key_i | input | 48 | Key of the entry to insert |
| ins_res_i | input | 8 | Classification result to store |
| hit_o | output | 1 | Lookup hit, one cycle after the request |
| miss_o | output | 1 | Lookup miss, one cycle after the request |
| res_o | output | 8 | Cached result on a hit, zero otherwise |

## Verification
Directed patterns fill one set with four keys that share a set index but have different digests. Keys are then touched in a chosen order, so an overflow insert shows whether the victim follows recency or way number. A key built by XORing equal values into two of its 16-bit slices keeps both folds, and it must produce a false hit. That separates digest tagging from exact matching. Re-inserting a present key shows whether the design overwrites or duplicates. A same-cycle lookup and insert shows whether the lookup reads the contents from before the insert. Random traffic over a small key pool, mixing hits, misses, refills and simultaneous requests, is compared with a bench model of sets, digests and recency.

// File: rtl/digest_cls_cache.sv
module digest_cls_cache #(
  parameter int KEY_W = 48,
  parameter int DIG_W = 16,
  parameter int RES_W = 8,
  parameter int SETS  = 16,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkp_vld_i,
  input  logic [KEY_W-1:0] lkp_key_i,
  input  logic             ins_vld_i,
  input  logic [KEY_W-1:0] ins_key_i,
  input  logic [RES_W-1:0] ins_res_i,
  output logic             hit_o,
  output logic             miss_o,
  output logic [RES_W-1:0] res_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [DIG_W-1:0] dig_q [SETS][WAYS];
  logic [RES_W-1:0] res_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  function automatic logic [IDX_W-1:0] fold_idx(input logic [KEY_W-1:0] k);
    fold_idx = '0;
    for (int i = 0; i < KEY_W / IDX_W; i++) fold_idx ^= k[i*IDX_W +: IDX_W];
  endfunction

  function automatic logic [DIG_W-1:0] fold_dig(input logic [KEY_W-1:0] k);
    fold_dig = '0;
    for (int i = 0; i < KEY_W / DIG_W; i++) fold_dig ^= k[i*DIG_W +: DIG_W];
  endfunction

  wire [IDX_W-1:0] l_set = fold_idx(lkp_key_i);
  wire [DIG_W-1:0] l_dig = fold_dig(lkp_key_i);
  wire [IDX_W-1:0] i_set = fold_idx(ins_key_i);
  wire [DIG_W-1:0] i_dig = fold_dig(ins_key_i);

  logic [WAYS-1:0]  l_match, i_match, i_old;
  logic [WAY_W-1:0] l_way, i_mway, i_free, i_vic, i_way;

  always_comb begin
    l_way  = '0;
    i_mway = '0;
    i_free = '0;
    i_vic  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      l_match[w] = vld_q[l_set][w] && dig_q[l_set][w] == l_dig;
      i_match[w] = vld_q[i_set][w] && dig_q[i_set][w] == i_dig;
      i_old[w]   = age_q[i_set][w] == WAY_W'(WAYS - 1);
      if (l_match[w]) l_way = WAY_W'(w);
      if (i_match[w]) i_mway = WAY_W'(w);
      if (!vld_q[i_set][w]) i_free = WAY_W'(w);
      if (i_old[w]) i_vic = WAY_W'(w);
    end
  end

  wire l_hit  = |l_match;
  wire i_hit  = |i_match;
  wire i_full = &vld_q[i_set];
  assign i_way = i_hit ? i_mway : (!i_full ? i_free : i_vic);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
      res_o  <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          dig_q[s][w] <= '0;
          res_q[s][w] <= '0;
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      hit_o  <= lkp_vld_i && l_hit;
      miss_o <= lkp_vld_i && !l_hit;
      res_o  <= (lkp_vld_i && l_hit) ? res_q[l_set][l_way] : '0;
      if (ins_vld_i) begin
        dig_q[i_set][i_way] <= i_dig;
        res_q[i_set][i_way] <= ins_res_i;
        vld_q[i_set][i_way] <= 1'b1;
      end
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (ins_vld_i && IDX_W'(s) == i_set) begin
            if (WAY_W'(w) == i_way) age_q[s][w] <= '0;
            else if (age_q[s][w] < age_q[s][i_way]) age_q[s][w] <= age_q[s][w] + 1'b1;
          end else if (lkp_vld_i && l_hit && IDX_W'(s) == l_set) begin
            if (WAY_W'(w) == l_way) age_q[s][w] <= '0;
            else if (age_q[s][w] < age_q[s][l_way]) age_q[s][w] <= age_q[s][w] + 1'b1;
          end
        end
      end
    end
  end

  a_r1_excl: assert property (@(posedge clk) disable iff (!rst_n) !(hit_o && miss_o));
  a_r1_resp: assert property (@(posedge clk) disable iff (!rst_n) lkp_vld_i |=> (hit_o || miss_o));
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n) !lkp_vld_i |=> !(hit_o || miss_o));
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n) miss_o |-> res_o == '0);
  a_r6_one_victim: assert property (@(posedge clk) disable iff (!rst_n) $onehot(i_old));
  a_r5_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld_i && !i_hit && !i_full) |=>
      $countones(vld_q[$past(i_set)]) == $countones($past(vld_q[i_set])) + 1);
endmodule

// File: tb/digest_cls_cache_tb_top.sv
module digest_cls_cache_tb_top;
  logic clk = 0, rst_n = 0;
  logic lkp_vld = 0, ins_vld = 0;
  logic [47:0] lkp_key = '0, ins_key = '0;
  logic [7:0] ins_res = '0;
  logic hit, miss;
  logic [7:0] res;
  int checks = 0, errors = 0;

  int mv [16][4];
  int md [16][4];
  int mr [16][4];
  int ma [16][4];

  always #2 clk = ~clk;

  digest_cls_cache dut_i (
    .clk(clk), .rst_n(rst_n), .lkp_vld_i(lkp_vld), .lkp_key_i(lkp_key),
    .ins_vld_i(ins_vld), .ins_key_i(ins_key), .ins_res_i(ins_res),
    .hit_o(hit), .miss_o(miss), .res_o(res));

  function automatic int m_idx(input logic [47:0] k);
    logic [3:0] x = '0;
    for (int i = 0; i < 12; i++) x ^= k[i*4 +: 4];
    return int'(x);
  endfunction

  function automatic int m_dig(input logic [47:0] k);
    return int'(k[15:0] ^ k[31:16] ^ k[47:32]);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic touch(input int s, input int tw);
    int t = ma[s][tw];
    for (int w = 0; w < 4; w++)
      if (w == tw) ma[s][w] = 0;
      else if (ma[s][w] < t) ma[s][w]++;
  endtask

  task automatic model_reset();
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        mv[s][w] = 0; md[s][w] = 0; mr[s][w] = 0; ma[s][w] = w;
      end
  endtask

  task automatic cyc(input bit dl, input logic [47:0] lk, input bit di,
                     input logic [47:0] ik, input logic [7:0] ir, input string rq);
    int ls, ld, lw, is_, id, iw;
    bit eh;
    int er;
    @(negedge clk);
    lkp_vld = dl; lkp_key = lk; ins_vld = di; ins_key = ik; ins_res = ir;
    ls = m_idx(lk); ld = m_dig(lk); lw = -1;
    for (int w = 3; w >= 0; w--) if (mv[ls][w] != 0 && md[ls][w] == ld) lw = w;
    eh = dl && lw >= 0;
    er = eh ? mr[ls][lw] : 0;
    is_ = m_idx(ik); id = m_dig(ik); iw = -1;
    if (di) begin
      for (int w = 3; w >= 0; w--) if (mv[is_][w] != 0 && md[is_][w] == id) iw = w;
      if (iw < 0) for (int w = 3; w >= 0; w--) if (mv[is_][w] == 0) iw = w;
      if (iw < 0) for (int w = 0; w < 4; w++) if (ma[is_][w] == 3) iw = w;
      mv[is_][iw] = 1; md[is_][iw] = id; mr[is_][iw] = ir;
      touch(is_, iw);
    end
    if (eh && !(di && is_ == ls)) touch(ls, lw);
    @(posedge clk); #1;
    chk(hit == eh, rq, hit, eh);
    chk(miss == (dl && !eh), rq, miss, dl && !eh);
    chk(res == er[7:0], rq, res, er);
  endtask

  task automatic look(input logic [47:0] k, input string rq);
    cyc(1, k, 0, '0, '0, rq);
  endtask

  task automatic ins(input logic [47:0] k, input logic [7:0] r, input string rq);
    cyc(0, '0, 1, k, r, rq);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] k [4];
    logic [47:0] pool [40];
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(hit == 0 && miss == 0 && res == 0, "R10 reset outputs", {hit, miss}, 0);
    @(negedge clk); rst_n = 1;
    // R10, R4: empty cache misses after reset
    look(48'h1234_5678_9abc, "R10 empty miss");
    look(48'h0, "R4 zero key miss");
    // R2, R5: four keys, same set (index 1), distinct digests
    k[0] = {16'hAAAA, 16'hAAAA, 16'h0001};
    k[1] = {16'h5555, 16'h5555, 16'h0010};
    k[2] = {16'h0F0F, 16'h0F0F, 16'h0100};
    k[3] = {16'h3C3C, 16'h3C3C, 16'h1000};
    for (int i = 0; i < 4; i++) ins(k[i], 8'(8'h10 + i), "R5 fill");
    for (int i = 0; i < 4; i++) look(k[i], "R3 hit after fill");
    // R7: touch order now k0..k3; refresh k0 so k1 becomes oldest
    look(k[0], "R7 touch");
    ins({16'h0, 16'h0, 16'h0023}, 8'h55, "R6 overflow insert");
    look(k[1], "R6 lru evicted");
    look(k[0], "R6 kept");
    look(k[2], "R6 kept");
    look({16'h0, 16'h0, 16'h0023}, "R6 new entry");
    // R3: false hit from a colliding key
    look(k[0] ^ {16'h1234, 16'h1234, 16'h0}, "R3 digest collision");
    // R8: reinsertion overwrites, no duplicate
    ins(k[2], 8'h77, "R8 reinsert");
    look(k[2], "R8 new result");
    look(k[0], "R8 others intact");
    look(k[3], "R8 others intact");
    // R9: lookup and insert of the same absent key in one cycle
    cyc(1, 48'h0000_0000_0777, 1, 48'h0000_0000_0777, 8'h99, "R9 pre-insert view");
    look(48'h0000_0000_0777, "R9 after insert");
    // R1: idle cycle keeps both low
    cyc(0, '0, 0, '0, '0, "R1 idle");
    for (int i = 0; i < 40; i++) pool[i] = {$urandom, $urandom} & 48'h0000_0F0F_F0FF;
    for (int n = 0; n < 4000; n++) begin
      cyc($urandom_range(0, 3) != 0, pool[$urandom_range(0, 39)],
          $urandom_range(0, 2) == 0, pool[$urandom_range(0, 39)],
          8'($urandom), "R1 R3 R6 R7 R9 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule